// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block collects interrupt lines for a small shared-memory system of up to four CPUs and presents one interrupt request to each CPU. Every CPU owns 32 banked interrupt IDs: IDs 0 to 15 are software interrupts raised by any CPU, and IDs 16 to 31 come from that CPU's own private lines. IDs from 32 upward are shared lines. Each shared line is steered to exactly one CPU through a routing word. A route is used only when its valid flag is set.

Software reaches the block through a simple register port. A read returns its data one cycle after the request. The address space has a global region of 0x8000 bytes. The local window of CPU c starts at 0x8000 + c*0x1000. Enable, disable and completion each take an interrupt ID written as data. An acknowledge read returns the lowest eligible ID and marks that ID active. The ID cannot be taken again until software writes it back as complete.

Top module: `intc_mp_dist`

## Requirements
- R1: After reset the global enable, every CPU enable, every interrupt enable and every route are clear, `irq` is all zero, and an acknowledge read returns 0x3FF.
- R2: Bit 0 at global offset 0x0 is the global enable, and bit 0 at local offset 0x0 is that CPU's enable. A CPU gets no interrupt and acknowledges 0x3FF unless both are set. Both read back.
- R3: Writing an ID to local 0xA0 enables it, and writing it to 0xA4 disables it. IDs below 32 act only on the CPU whose window is written. Shared IDs act on one enable per line from any window. Out-of-range IDs are ignored.
- R4: The route for shared ID N is at global offset 0x1000 + 4*(N-32). Bit 31 is the valid flag and bits 7..0 are the target CPU number. An invalid route delivers the line to no CPU. The word reads back with the same layout.
- R5: A read of local 0x6C returns the lowest eligible ID (pending, enabled, routed to this CPU and not active), or 0x3FF if there is none. A real ID becomes active and stops being eligible.
- R6: A read of local 0x68 returns bit 31 = 1 if any eligible ID remains, with bits 9..0 holding the lowest such ID (0x3FF if none). The read has no side effect.
- R7: Writing an ID to local 0xB4 clears its active state. A level source that is still high becomes eligible again.
- R8: A write to local 0x60 sets software interrupt ID bits 3..0 pending on every CPU whose bit is set in bits 15..8. The pending state is cleared when that ID is acknowledged.
- R9: Banked state is independent per CPU. A software interrupt pending, enabled or active on one CPU does not change another CPU's view of the same ID.
- R10: `irq[c]` is a register. It reflects the state present after a write or acknowledge one clock edge later than that state changes.
- R11: `rd_valid` is high for exactly the cycle after each `rd_en`, and `rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data strobe, one cycle after rd_en |
| spi_lvl | input | NUM_IRQ-32 | Level inputs of shared IDs 32 and up |
| ppi_lvl | input | NCPU*16 | Private level inputs, 16 per CPU for IDs 16..31 |
| irq | output | NCPU | Interrupt request to each CPU |

## Verification
An acknowledge read and the arrival of a source can fall in the same cycle. The bench provokes this by holding a software interrupt and a private line on one CPU at the same time. It then acknowledges one and checks that the other is still reported by the pending register and by the next acknowledge. A second collision is between completion and a level line that is still asserted. The bench completes while the line is high and expects `irq` to rise again, then drops the line and expects the next acknowledge to return 0x3FF.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;
  localparam int GLB_SIZE   = 32'h8000;
  localparam int ROUTE_BASE = 32'h1000;
  localparam logic [11:0] OFF_CTL  = 12'h000;
  localparam logic [11:0] OFF_IPI  = 12'h060;
  localparam logic [11:0] OFF_PEND = 12'h068;
  localparam logic [11:0] OFF_ACK  = 12'h06C;
  localparam logic [11:0] OFF_SEN  = 12'h0A0;
  localparam logic [11:0] OFF_CEN  = 12'h0A4;
  localparam logic [11:0] OFF_EOI  = 12'h0B4;

  typedef struct packed {
    logic       ok;
    logic [7:0] cpu;
  } route_t;
endpackage

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N   = 64,
  parameter int IDW = 10
) (
  input  logic [N-1:0]   req,
  output logic           any,
  output logic [IDW-1:0] id
);
  always_comb begin
    any = |req;
    id  = {IDW{1'b1}};
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = IDW'(i);
    end
  end
endmodule

// File: rtl/intc_route_tbl.sv
module intc_route_tbl import intc_pkg::*; #(
  parameter int NCPU = 4,
  parameter int NSH  = 32,
  localparam int SH_W = (NSH > 1) ? $clog2(NSH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [SH_W-1:0]      idx,
  input  logic                 w_ok,
  input  logic [7:0]           w_cpu,
  output logic [31:0]          rd_word,
  output logic [NCPU*NSH-1:0]  dest
);
  route_t tbl [NSH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSH; s++) tbl[s] <= '0;
    end else if (wr) begin
      tbl[idx] <= '{ok: w_ok, cpu: w_cpu};
    end
  end

  assign rd_word = {tbl[idx].ok, 23'd0, tbl[idx].cpu};

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSH; s++) begin : g_src
      assign dest[c*NSH+s] = tbl[s].ok && (tbl[s].cpu == 8'(c));
    end
  end
endmodule

// File: rtl/intc_cpu_if.sv
module intc_cpu_if import intc_pkg::*; #(
  parameter int NUM_IRQ = 64,
  localparam int NSH = NUM_IRQ - 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            glb_en,
  input  logic            wr_ctl,
  input  logic            wr_sen,
  input  logic            wr_cen,
  input  logic            wr_eoi,
  input  logic            rd_ack,
  input  logic            ctl_bit,
  input  logic [ID_W-1:0] wid,
  input  logic [15:0]     ipi_set,
  input  logic [15:0]     ppi_lvl,
  input  logic [NSH-1:0]  sh_req,
  output logic            en,
  output logic            irq,
  output logic            any,
  output logic [ID_W-1:0] top_id,
  output logic            ack_sh
);
  logic [31:0]        priv_en, priv_act;
  logic [15:0]        ipi_pend, ipi_clr;
  logic [NUM_IRQ-1:0] cand;
  logic               wid_priv, take, take_priv;

  assign wid_priv = (wid < ID_W'(32));
  assign cand = (glb_en && en) ?
                {sh_req, ({ppi_lvl, ipi_pend} & priv_en & ~priv_act)} : '0;

  intc_prio_enc #(.N(NUM_IRQ), .IDW(ID_W)) u_enc (
    .req(cand), .any(any), .id(top_id)
  );

  assign take      = rd_ack && any;
  assign take_priv = take && (top_id < ID_W'(32));
  assign ack_sh    = take && (top_id >= ID_W'(32));
  assign ipi_clr   = (take && (top_id < ID_W'(16))) ? (16'd1 << top_id[3:0]) : 16'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      priv_en  <= '0;
      priv_act <= '0;
      ipi_pend <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctl) en <= ctl_bit;
      if (wr_sen && wid_priv) priv_en[wid[4:0]] <= 1'b1;
      if (wr_cen && wid_priv) priv_en[wid[4:0]] <= 1'b0;
      if (wr_eoi && wid_priv) priv_act[wid[4:0]] <= 1'b0;
      if (take_priv) priv_act[top_id[4:0]] <= 1'b1;
      ipi_pend <= (ipi_pend & ~ipi_clr) | ipi_set;
      irq      <= |cand;
    end
  end
endmodule

// File: rtl/intc_mp_dist.sv
module intc_mp_dist import intc_pkg::*; #(
  parameter int NCPU    = 4,
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 rd_valid,
  input  logic [NUM_IRQ-33:0]  spi_lvl,
  input  logic [NCPU*16-1:0]   ppi_lvl,
  output logic [NCPU-1:0]      irq
);
  localparam int NSH   = NUM_IRQ - 32;
  localparam int SH_W  = (NSH > 1) ? $clog2(NSH) : 1;
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic               glb_en;
  logic [NSH-1:0]     sh_en, sh_act;
  logic [NCPU-1:0]    cpu_en_v, any_v, ack_sh_v;
  logic [ID_W-1:0]    id_a [NCPU];
  logic [NCPU*NSH-1:0] dest;
  logic [31:0]        rt_word, rd_mux;

  logic              is_glb, lhit, rt_hit, glb_ctl, ipi_hit, wid_sh;
  logic [ADDR_W-1:0] loc, r_off;
  logic [CPU_W-1:0]  sel;
  logic [11:0]       loff;
  logic [SH_W-1:0]   rt_idx, sh_i;
  logic [ID_W-1:0]   wid;
  logic              unused_bits;

  assign unused_bits = ^wdata[30:16];

  assign is_glb  = addr < ADDR_W'(GLB_SIZE);
  assign loc     = addr - ADDR_W'(GLB_SIZE);
  assign sel     = CPU_W'(loc >> 12);
  assign loff    = 12'(loc);
  assign lhit    = !is_glb && ((loc >> 12) < ADDR_W'(NCPU));
  assign glb_ctl = is_glb && (addr == '0);
  assign r_off   = addr - ADDR_W'(ROUTE_BASE);
  assign rt_hit  = is_glb && (addr >= ADDR_W'(ROUTE_BASE)) &&
                   (r_off < ADDR_W'(4 * NSH)) && (addr[1:0] == 2'b00);
  assign rt_idx  = SH_W'(r_off >> 2);
  assign ipi_hit = wr_en && lhit && (loff == OFF_IPI);
  assign wid     = wdata[ID_W-1:0];
  assign wid_sh  = (wid >= ID_W'(32)) && (wid < ID_W'(NUM_IRQ));
  assign sh_i    = SH_W'(wid - ID_W'(32));

  intc_route_tbl #(.NCPU(NCPU), .NSH(NSH)) u_rt (
    .clk(clk), .rst(rst), .wr(wr_en && rt_hit), .idx(rt_idx),
    .w_ok(wdata[31]), .w_cpu(wdata[7:0]), .rd_word(rt_word), .dest(dest)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit_c;
    assign hit_c = lhit && (sel == CPU_W'(c));
    intc_cpu_if #(.NUM_IRQ(NUM_IRQ)) u_if (
      .clk(clk), .rst(rst), .glb_en(glb_en),
      .wr_ctl(wr_en && hit_c && (loff == OFF_CTL)),
      .wr_sen(wr_en && hit_c && (loff == OFF_SEN)),
      .wr_cen(wr_en && hit_c && (loff == OFF_CEN)),
      .wr_eoi(wr_en && hit_c && (loff == OFF_EOI)),
      .rd_ack(rd_en && hit_c && (loff == OFF_ACK)),
      .ctl_bit(wdata[0]), .wid(wid),
      .ipi_set((ipi_hit && wdata[8+c]) ? (16'd1 << wdata[3:0]) : 16'd0),
      .ppi_lvl(ppi_lvl[c*16 +: 16]),
      .sh_req(dest[c*NSH +: NSH] & spi_lvl & sh_en & ~sh_act),
      .en(cpu_en_v[c]), .irq(irq[c]), .any(any_v[c]), .top_id(id_a[c]),
      .ack_sh(ack_sh_v[c])
    );
  end

  // Shared enable and active state, reachable from any CPU window
  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en <= 1'b0;
      sh_en  <= '0;
      sh_act <= '0;
    end else begin
      if (wr_en && glb_ctl) glb_en <= wdata[0];
      if (wr_en && lhit && wid_sh) begin
        if (loff == OFF_SEN) sh_en[sh_i]  <= 1'b1;
        if (loff == OFF_CEN) sh_en[sh_i]  <= 1'b0;
        if (loff == OFF_EOI) sh_act[sh_i] <= 1'b0;
      end
      for (int c = 0; c < NCPU; c++) begin
        if (ack_sh_v[c]) sh_act[SH_W'(id_a[c] - ID_W'(32))] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (glb_ctl)     rd_mux = {31'd0, glb_en};
    else if (rt_hit) rd_mux = rt_word;
    else if (lhit) begin
      case (loff)
        OFF_CTL:  rd_mux = {31'd0, cpu_en_v[sel]};
        OFF_PEND: rd_mux = {any_v[sel], 21'd0, id_a[sel]};
        OFF_ACK:  rd_mux = {22'd0, id_a[sel]};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rdata    <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/intc_mp_dist_chk.sv
module intc_mp_dist_chk #(
  parameter int NCPU   = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [NCPU-1:0]   irq,
  input logic [NCPU-1:0]   cpu_en,
  input logic              glb_en
);
  // R11
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R11
  rd_origin_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R2
  glb_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0 && !wdata[0]) |-> ##2 (irq == '0));

  // R2
  cpu_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq & ~$past(cpu_en)) == '0);

  // R2
  glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> $past(glb_en));
endmodule

bind intc_mp_dist intc_mp_dist_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid),
  .addr(addr), .wdata(wdata), .irq(irq), .cpu_en(cpu_en_v), .glb_en(glb_en)
);

// File: tb/sim_intc_mp_dist.sv
module sim_intc_mp_dist;
  localparam int NCPU = 4;
  localparam int NUM_IRQ = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [NUM_IRQ-33:0] spi_lvl = '0;
  logic [NCPU*16-1:0]  ppi_lvl = '0;
  logic [NCPU-1:0]     irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  intc_mp_dist #(.NCPU(NCPU), .NUM_IRQ(NUM_IRQ), .ADDR_W(16)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .spi_lvl(spi_lvl), .ppi_lvl(ppi_lvl), .irq(irq)
  );

  function automatic logic [15:0] la(int c, int off);
    return 16'(32'h8000 + c * 32'h1000 + off);
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares it
  task automatic rd(logic [15:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(logic [NCPU-1:0] e, string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic irq_after(logic [NCPU-1:0] e, string tag);
    @(negedge clk);
    chk_irq(e, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected read data actual %h expected none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    irq_after(4'b0000, "R1");
    rd(la(0, 'h6C), 32'h3FF, "R1 ack");
    rd(16'h1020, 32'h0, "R1 route");
    rd(16'h0000, 32'h0, "R1 glb");
    // R2 enables
    wr(16'h0000, 1);
    for (int c = 0; c < NCPU; c++) wr(la(c, 0), 1);
    rd(16'h0000, 32'h1, "R2 glb");
    rd(la(2, 0), 32'h1, "R2 cpu");
    // R8 IPI id 5 to cpu1 and cpu2, not yet enabled
    wr(la(0, 'h60), 32'h0000_0605);
    irq_after(4'b0000, "R3 disabled id");
    wr(la(1, 'hA0), 5);
    irq_after(4'b0010, "R8 ipi");
    rd(la(1, 'h68), 32'h8000_0005, "R6 pend");
    rd(la(1, 'h6C), 32'h5, "R5 ack");
    irq_after(4'b0000, "R5 active");
    rd(la(1, 'h68), 32'h0000_03FF, "R6 empty");
    wr(la(1, 'hB4), 5);
    irq_after(4'b0000, "R8 pend cleared");
    // R9 cpu2 banked copy still pending
    wr(la(2, 'hA0), 5);
    irq_after(4'b0100, "R9 banked");
    rd(la(2, 'h6C), 32'h5, "R9 ack");
    wr(la(2, 'hB4), 5);
    // R5 ordering: private line 20 and IPI 3 on cpu3
    ppi_lvl[3*16+4] = 1'b1;
    wr(la(3, 'hA0), 20);
    wr(la(3, 'hA0), 3);
    wr(la(0, 'h60), 32'h0000_0803);
    rd(la(3, 'h6C), 32'h3, "R5 lowest");
    rd(la(3, 'h68), 32'h8000_0014, "R6 another");
    rd(la(3, 'h6C), 32'h14, "R5 next");
    rd(la(3, 'h6C), 32'h3FF, "R5 none");
    wr(la(3, 'hB4), 20);
    irq_after(4'b1000, "R7 level retake");
    rd(la(3, 'h6C), 32'h14, "R7 ack again");
    ppi_lvl[3*16+4] = 1'b0;
    wr(la(3, 'hB4), 20);
    wr(la(3, 'hB4), 3);
    irq_after(4'b0000, "R7 quiet");
    rd(la(3, 'h6C), 32'h3FF, "R7 none");
    // R4 shared id 40
    spi_lvl[8] = 1'b1;
    wr(la(0, 'hA0), 40);
    irq_after(4'b0000, "R4 no route");
    wr(16'h1020, 32'h8000_0002);
    chk_irq(4'b0000, "R10 old value");
    irq_after(4'b0100, "R4 routed");
    rd(16'h1020, 32'h8000_0002, "R4 readback");
    rd(la(2, 'h6C), 32'd40, "R5 shared ack");
    irq_after(4'b0000, "R5 shared active");
    wr(la(2, 'hB4), 40);
    irq_after(4'b0100, "R7 shared retake");
    wr(la(1, 'hA4), 40);
    irq_after(4'b0000, "R3 shared disable");
    wr(la(3, 'hA0), 40);
    wr(16'h1020, 32'h8000_0000);
    irq_after(4'b0001, "R4 retarget");
    wr(la(0, 'hA0), 200);
    irq_after(4'b0001, "R3 out of range");
    // R2 gating
    wr(16'h0000, 0);
    irq_after(4'b0000, "R2 glb off");
    rd(la(0, 'h6C), 32'h3FF, "R2 glb off ack");
    wr(16'h0000, 1);
    irq_after(4'b0001, "R2 glb on");
    wr(la(0, 0), 0);
    irq_after(4'b0000, "R2 cpu off");
    wr(la(0, 0), 1);
    wr(16'h1020, 32'h0000_0000);
    irq_after(4'b0000, "R4 invalid");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 reads outstanding actual %0d expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule